// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block replaces a firmware bring-up routine for a DDR2 memory controller. Once launched, it issues a fixed series of register writes toward the controller through a plain write port: an address, a 32-bit data word and a one-cycle write strobe. The series enables the PHY clock, then resets and calibrates the PHY. Next it steps through the standard DDR2 mode-register, precharge and refresh commands. Finally it loads the timing, latency and configuration registers.

A programmable wait, counted in clock cycles, comes before the first write. The same wait follows the PHY clock enable, the calibration start and every memory command. Each memory command is one write to the controller's command register. The write carries an 8-bit command code in bits 23:16 and a 16-bit argument in bits 15:0.

Parameters supply the register addresses, the mode value and the three final words. When the last write is done, a done flag rises and stays high until reset. A start pulse launches the run. The `AUTO_START` parameter can instead launch it as soon as reset is released.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `wr_en` and `done` are low. With `AUTO_START`=0, no write happens before `start` is sampled high.
- R2: The first write appears exactly `DELAY_CYCLES` cycles after the clock edge that samples `start`. It goes to the PHY configuration address with data 32'h0000_0001 (bit 0 is the clock enable).
- R3: After the wait that follows the clock enable, the PHY control address receives two writes on back-to-back cycles. The first is 32'h0000_0003 (bit 0 is PHY reset, bit 1 is calibration reset). The second is 32'h0000_0004 (bit 2 is calibration start).
- R4: Each memory command is one write to the command address with data {8'h00, code[7:0], arg[15:0]}. The codes are: mode register 8'h00, refresh 8'h01, precharge 8'h02, deselect 8'h07, extended mode 8'h10, extended mode 2 8'h11, extended mode 3 8'h12.
- R5: Twelve commands are issued, in this order, with these arguments:
  1. deselect, 0
  2. precharge, 16'h0400 (all banks)
  3. extended mode 2, 0
  4. extended mode 3, 0
  5. extended mode, 16'h0000 (DLL enabled)
  6. mode register, 16'h0100 (DLL reset)
  7. precharge, 16'h0400
  8. refresh, 0
  9. refresh, 0
  10. mode register, `MODE_WORD[15:0]`
  11. extended mode, 16'h0380 (OCD default)
  12. extended mode, 16'h0000 | `MODE_WORD[31:16]` (OCD exit)
- R6: These writes are each followed by exactly `DELAY_CYCLES` cycles with no write: the PHY clock enable, the calibration start and every command. The counter reloads to the full length for every wait.
- R7: After the wait that follows the last command, the timing, latency and configuration addresses are written on three consecutive cycles, in that order. The data words are `TIMING_WORD`, `LATENCY_WORD` and `CONFIG_WORD`.
- R8: `done` rises in the cycle after the configuration write and stays high until reset. No write follows it.
- R9: `start` has no effect while a run is in progress or after `done`. The write order and the spacing between writes are unchanged.
- R10: The write strobe is high for a single cycle per write, and each run issues exactly 18 writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches the sequence once when sampled high in the idle state |
| wr_en | output | 1 | Write strobe, one cycle per register write |
| wr_addr | output | ADDR_W | Register address of the current write |
| wr_data | output | 32 | Data word of the current write |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The first write is due `DELAY_CYCLES` edges after the edge that samples `start`, so at the bench's cycle count it appears `DELAY_CYCLES`+1 counts after the negative edge that drives `start`. A write that carries a wait is followed by the next write `DELAY_CYCLES`+1 cycles later; the three final writes follow one cycle apart; `done` is due one cycle after the configuration write. The driver queues each expected address, data word and cycle gap. The monitor samples on the falling clock edge, so each write is compared in the cycle it is strobed. A strobe that arrives early, late or after the queue is empty is reported.

// File: rtl/brup_pkg.sv
// Package: shared types and DDR2 command constants for the bring-up sequencer.
// Assumes a 32-bit controller write port; command codes sit in bits 23:16.
package brup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } state_t;

    typedef enum logic [2:0] {
        RS_PHY_CFG  = 3'd0,
        RS_PHY_CTRL = 3'd1,
        RS_CMD      = 3'd2,
        RS_TIMING   = 3'd3,
        RS_LATENCY  = 3'd4,
        RS_CONFIG   = 3'd5
    } reg_sel_t;

    localparam int unsigned NUM_STEPS  = 18;
    localparam int unsigned STEP_W     = $clog2(NUM_STEPS);
    localparam int unsigned FIRST_CMD  = 3;
    localparam int unsigned LAST_CMD   = 14;

    // memory command codes
    localparam logic [7:0] CMD_MRS     = 8'h00;
    localparam logic [7:0] CMD_REFRESH = 8'h01;
    localparam logic [7:0] CMD_PRECHG  = 8'h02;
    localparam logic [7:0] CMD_DESEL   = 8'h07;
    localparam logic [7:0] CMD_EMR     = 8'h10;
    localparam logic [7:0] CMD_EMR2    = 8'h11;
    localparam logic [7:0] CMD_EMR3    = 8'h12;

    // command argument fields
    localparam logic [15:0] ARG_ALL_BANKS = 16'h0400;
    localparam logic [15:0] ARG_DLL_ON    = 16'h0000;
    localparam logic [15:0] ARG_DLL_RESET = 16'h0100;
    localparam logic [15:0] ARG_OCD_DFLT  = 16'h0380;
    localparam logic [15:0] ARG_OCD_EXIT  = 16'h0000;

    // PHY register bits
    localparam logic [31:0] PHY_CLK_EN    = 32'h0000_0001;
    localparam logic [31:0] PHY_RESET     = 32'h0000_0001;
    localparam logic [31:0] PHY_CAL_RESET = 32'h0000_0002;
    localparam logic [31:0] PHY_CAL_GO    = 32'h0000_0004;

    // Pack a command code above its argument into one command-register word.
    function automatic logic [31:0] pack_cmd(input logic [7:0] code, input logic [15:0] arg);
        return {8'h00, code, arg};
    endfunction

endpackage

// File: rtl/brup_delay.sv
// Module: wait timer. Counts a full DELAY_CYCLES period after each load.
// Assumes DELAY_CYCLES >= 1; 'zero' is high in the last cycle of a wait.
module brup_delay #(
    parameter int unsigned DELAY_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // reload to the full period on request, else count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(DELAY_CYCLES - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // a freshly loaded wait never ends in its first cycle (R6)
    p_no_early_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && DELAY_CYCLES > 1) |=> !zero);

    // a running count only moves down by one (R6)
    p_steady_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/brup_step_rom.sv
// Module: step table. Maps a step index to register select, data word and
// whether a wait follows. Purely combinational; indices past the end are inert.
module brup_step_rom #(
    parameter logic [31:0] MODE_WORD    = 32'h0004_0632,
    parameter logic [31:0] TIMING_WORD  = 32'h0A1B_2C3D,
    parameter logic [31:0] LATENCY_WORD = 32'h0000_0033,
    parameter logic [31:0] CONFIG_WORD  = 32'h8000_0102
) (
    input  logic [brup_pkg::STEP_W-1:0] idx,
    output brup_pkg::reg_sel_t          sel,
    output logic [31:0]                 data,
    output logic                        wait_after,
    output logic                        last
);
    import brup_pkg::*;

    // decode the step index into its write and its wait flag
    always_comb begin
        sel        = RS_CMD;
        data       = '0;
        wait_after = 1'b1;
        unique case (idx)
            5'd0:  begin sel = RS_PHY_CFG;  data = PHY_CLK_EN; end
            5'd1:  begin sel = RS_PHY_CTRL; data = PHY_RESET | PHY_CAL_RESET; wait_after = 1'b0; end
            5'd2:  begin sel = RS_PHY_CTRL; data = PHY_CAL_GO; end
            5'd3:  data = pack_cmd(CMD_DESEL,   16'h0000);
            5'd4:  data = pack_cmd(CMD_PRECHG,  ARG_ALL_BANKS);
            5'd5:  data = pack_cmd(CMD_EMR2,    16'h0000);
            5'd6:  data = pack_cmd(CMD_EMR3,    16'h0000);
            5'd7:  data = pack_cmd(CMD_EMR,     ARG_DLL_ON);
            5'd8:  data = pack_cmd(CMD_MRS,     ARG_DLL_RESET);
            5'd9:  data = pack_cmd(CMD_PRECHG,  ARG_ALL_BANKS);
            5'd10: data = pack_cmd(CMD_REFRESH, 16'h0000);
            5'd11: data = pack_cmd(CMD_REFRESH, 16'h0000);
            5'd12: data = pack_cmd(CMD_MRS,     MODE_WORD[15:0]);
            5'd13: data = pack_cmd(CMD_EMR,     ARG_OCD_DFLT | ARG_DLL_ON);
            5'd14: data = pack_cmd(CMD_EMR,     ARG_OCD_EXIT | ARG_DLL_ON | MODE_WORD[31:16]);
            5'd15: begin sel = RS_TIMING;  data = TIMING_WORD;  wait_after = 1'b0; end
            5'd16: begin sel = RS_LATENCY; data = LATENCY_WORD; wait_after = 1'b0; end
            5'd17: begin sel = RS_CONFIG;  data = CONFIG_WORD;  wait_after = 1'b0; end
            default: begin sel = RS_CONFIG; data = '0; wait_after = 1'b0; end
        endcase
    end

    assign last = (idx == STEP_W'(NUM_STEPS - 1));

endmodule

// File: rtl/brup_ctrl.sv
// Module: sequence controller. Walks the step table once per reset:
// initial wait, then write / optional wait per step, then done.
// Assumes the wait timer asserts 'delay_zero' in the final cycle of a wait.
module brup_ctrl #(
    parameter bit AUTO_START = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        delay_zero,
    input  logic                        step_wait,
    input  logic                        step_last,
    output brup_pkg::state_t            state,
    output logic [brup_pkg::STEP_W-1:0] idx,
    output logic                        load,
    output logic                        wr_en,
    output logic                        done
);
    import brup_pkg::*;

    state_t            state_n;
    logic [STEP_W-1:0] idx_n;
    logic              launch;

    // pick the launch source: reset release or an explicit start pulse
    generate
        if (AUTO_START) begin : g_auto
            assign launch = 1'b1;
        end else begin : g_pulse
            assign launch = start;
        end
    endgenerate

    // next-state, step advance and timer reload
    always_comb begin
        state_n = state;
        idx_n   = idx;
        load    = 1'b0;
        unique case (state)
            ST_IDLE:  if (launch) begin state_n = ST_WAIT; load = 1'b1; end
            ST_WAIT:  if (delay_zero) state_n = ST_WRITE;
            ST_WRITE: begin
                if (step_last) begin
                    state_n = ST_DONE;
                end else begin
                    idx_n = idx + 1'b1;
                    if (step_wait) begin
                        state_n = ST_WAIT;
                        load    = 1'b1;
                    end
                end
            end
            default:  state_n = ST_DONE;
        endcase
    end

    // state and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    assign wr_en = (state == ST_WRITE);
    assign done  = (state == ST_DONE);

    // start during a run neither restarts nor skips steps (R9)
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && start && !delay_zero) |=> (state == ST_WAIT && idx == $past(idx)));

    // completion is permanent until reset (R8)
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/ddr2_bringup_seq.sv
// Module: DDR2 power-up initialization sequencer (top).
// Issues the PHY bring-up, DDR2 command list and final register loads as
// single-cycle writes on a simple address/data/strobe port, then raises done.
// Assumes the controller accepts one write per cycle without back-pressure.
module ddr2_bringup_seq #(
    parameter int unsigned DELAY_CYCLES = 10000,
    parameter int unsigned ADDR_W       = 8,
    parameter bit          AUTO_START   = 1'b0,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CFG  = 8'h04,
    parameter logic [ADDR_W-1:0] ADDR_PHY_CTRL = 8'h08,
    parameter logic [ADDR_W-1:0] ADDR_CMD      = 8'h0C,
    parameter logic [ADDR_W-1:0] ADDR_TIMING   = 8'h10,
    parameter logic [ADDR_W-1:0] ADDR_LATENCY  = 8'h14,
    parameter logic [ADDR_W-1:0] ADDR_CONFIG   = 8'h18,
    parameter logic [31:0] MODE_WORD    = 32'h0004_0632,
    parameter logic [31:0] TIMING_WORD  = 32'h0A1B_2C3D,
    parameter logic [31:0] LATENCY_WORD = 32'h0000_0033,
    parameter logic [31:0] CONFIG_WORD  = 32'h8000_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              done
);
    import brup_pkg::*;

    state_t            state;
    logic [STEP_W-1:0] idx;
    logic              load;
    logic              delay_zero;
    reg_sel_t          sel;
    logic              step_wait;
    logic              step_last;

    brup_ctrl #(.AUTO_START(AUTO_START)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .delay_zero (delay_zero),
        .step_wait  (step_wait),
        .step_last  (step_last),
        .state      (state),
        .idx        (idx),
        .load       (load),
        .wr_en      (wr_en),
        .done       (done)
    );

    brup_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .zero  (delay_zero)
    );

    brup_step_rom #(
        .MODE_WORD    (MODE_WORD),
        .TIMING_WORD  (TIMING_WORD),
        .LATENCY_WORD (LATENCY_WORD),
        .CONFIG_WORD  (CONFIG_WORD)
    ) u_rom (
        .idx        (idx),
        .sel        (sel),
        .data       (wr_data),
        .wait_after (step_wait),
        .last       (step_last)
    );

    // map the step's register select onto a port address
    always_comb begin
        unique case (sel)
            RS_PHY_CFG:  wr_addr = ADDR_PHY_CFG;
            RS_PHY_CTRL: wr_addr = ADDR_PHY_CTRL;
            RS_CMD:      wr_addr = ADDR_CMD;
            RS_TIMING:   wr_addr = ADDR_TIMING;
            RS_LATENCY:  wr_addr = ADDR_LATENCY;
            default:     wr_addr = ADDR_CONFIG;
        endcase
    end

    // no write slips out before the timer has run out (R6)
    p_wait_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !delay_zero) |=> !wr_en);

    // a write that carries a wait is a lone one-cycle strobe (R10)
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && step_wait) |=> !wr_en);

    // memory commands always target the command register (R4)
    p_cmd_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= STEP_W'(FIRST_CMD) && idx <= STEP_W'(LAST_CMD)) |-> (wr_addr == ADDR_CMD));

    // nothing is written once the sequence has completed (R8)
    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_en);

endmodule

// File: tb/ddr2_bringup_seq_tb_top.sv
// Scoreboard bench: the driver queues expected writes with their cycle gaps,
// the monitor checks each strobe as it appears.
module ddr2_bringup_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;
    localparam logic [31:0] MODE = 32'h0004_0632;
    localparam logic [31:0] TIMW = 32'h0A1B_2C3D;
    localparam logic [31:0] LATW = 32'h0000_0033;
    localparam logic [31:0] CFGW = 32'h8000_0102;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] data;
        int          gap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        done;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   last_cyc = 0;
    int   writes_seen = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_bringup_seq #(
        .DELAY_CYCLES (DLY),
        .ADDR_W       (8),
        .AUTO_START   (1'b0),
        .MODE_WORD    (MODE),
        .TIMING_WORD  (TIMW),
        .LATENCY_WORD (LATW),
        .CONFIG_WORD  (CFGW)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done    (done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [31:0] d, input int gap, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.gap = gap; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic logic [31:0] cmdw(input logic [7:0] code, input logic [15:0] arg);
        return {8'h00, code, arg};
    endfunction

    // driver: expected writes for one full run
    task automatic push_run();
        push(8'h04, 32'h1, DLY + 1, "R2 clock enable");
        push(8'h08, 32'h3, DLY + 1, "R3 phy reset");
        push(8'h08, 32'h4, 1,       "R3 cal start");
        push(8'h0C, cmdw(8'h07, 16'h0000), DLY + 1, "R5 deselect");
        push(8'h0C, cmdw(8'h02, 16'h0400), DLY + 1, "R5 precharge all");
        push(8'h0C, cmdw(8'h11, 16'h0000), DLY + 1, "R5 emr2");
        push(8'h0C, cmdw(8'h12, 16'h0000), DLY + 1, "R5 emr3");
        push(8'h0C, cmdw(8'h10, 16'h0000), DLY + 1, "R4 emr dll on");
        push(8'h0C, cmdw(8'h00, 16'h0100), DLY + 1, "R4 mrs dll reset");
        push(8'h0C, cmdw(8'h02, 16'h0400), DLY + 1, "R5 precharge all");
        push(8'h0C, cmdw(8'h01, 16'h0000), DLY + 1, "R5 refresh");
        push(8'h0C, cmdw(8'h01, 16'h0000), DLY + 1, "R6 refresh");
        push(8'h0C, cmdw(8'h00, MODE[15:0]), DLY + 1, "R4 mrs mode");
        push(8'h0C, cmdw(8'h10, 16'h0380), DLY + 1, "R5 emr ocd default");
        push(8'h0C, cmdw(8'h10, MODE[31:16]), DLY + 1, "R5 emr ocd exit");
        push(8'h10, TIMW, DLY + 1, "R7 timing");
        push(8'h14, LATW, 1,       "R7 latency");
        push(8'h18, CFGW, 1,       "R7 config");
    endtask

    // monitor: compare each strobe against the head of the queue
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            writes_seen++;
            if (q.size() == 0) begin
                check(1'b0, "R8 unexpected write", {24'h0, wr_addr}, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(wr_addr == e.addr, {e.tag, " addr"}, {24'h0, wr_addr}, {24'h0, e.addr});
                check(wr_data == e.data, {e.tag, " data"}, wr_data, e.data);
                check((cyc - last_cyc) == e.gap, {e.tag, " gap"}, cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1 during reset", {wr_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0, "R1 after reset", {wr_en, done}, 0);
        repeat (2 * DLY) @(negedge clk);
        check(writes_seen == 0, "R1 no launch without start", writes_seen, 0);

        push_run();
        start = 1'b1;
        last_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        // stray start pulses during a wait and around the PHY writes (R9)
        repeat (DLY / 2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (DLY + 3) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(q.size() == 0, "R10 all writes seen", q.size(), 0);
        check(writes_seen == 18, "R10 write count", writes_seen, 18);
        check((cyc - last_cyc) == 1, "R8 done one cycle after config", cyc - last_cyc, 1);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3 * DLY) @(negedge clk);
        check(done == 1'b1, "R8 done sticky", done, 1);
        check(writes_seen == 18, "R9 start after done ignored", writes_seen, 18);

        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b0 && wr_en == 1'b0, "R1 reset clears done", {wr_en, done}, 0);
        rst_n = 1'b1;
        repeat (2 * DLY) @(negedge clk);
        check(writes_seen == 18 && done == 1'b0, "R1 idle after reset", writes_seen, 18);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule